// File: doc/BRIEF.md
# Multiprocessor-Mode Asynchronous Serial Receiver

This block receives asynchronous serial frames on a line that several nodes share. A frame is a low start bit, 7, 8 or 9 data bits sent least significant bit first, an optional extra bit, and a high stop bit. The block samples at the centre of each bit and times everything from a 16x oversampling enable, `os_tick`. The extra bit is either a parity bit or, in multiprocessor mode, an address marker (the MP bit). Multiprocessor mode is valid only for 7-bit and 8-bit data.

Software arms a wake flag to skip traffic meant for other nodes. While the flag is set in multiprocessor mode, frames whose MP bit is 0 are dropped without a trace. The first frame with MP bit 1 clears the flag in hardware and is delivered as a normal frame. An optional persistence filter on the line ignores any pulse of three ticks or fewer.

The frame engine has five states. `RX_IDLE` waits for a tick that sees the line low, then goes to `RX_START`. `RX_START` checks the line at mid-start: if the line is high it returns to `RX_IDLE` (false start), otherwise it goes to `RX_DATA`. `RX_DATA` takes one bit per 16 ticks. After the last data bit it goes to `RX_EXTRA` when an extra bit is expected, else to `RX_STOP`. `RX_EXTRA` takes the extra bit and goes to `RX_STOP`. `RX_STOP` samples the stop bit, reports the frame and returns to `RX_IDLE`.

Top module: `mp_uart_rx`

## Requirements
- R1: After reset, `rx_done`, `ovr_err`, `frm_err`, `par_err`, `wake_en`, `rx_mp_bit` and `rx_data` are all 0.
- R2: `len_code` selects the data length: 0 = 7 bits, 1 = 8 bits, 2 or 3 = 9 bits. Data arrive LSB first and are right-aligned in `rx_data`, with the upper bits zero.
- R3: When parity is in use, a parity bit follows the data. `par_odd` = 0 asks for even parity (data plus parity bit hold an even number of ones) and 1 asks for odd. A mismatch sets `par_err`.
- R4: Multiprocessor mode takes effect only when `len_code` is 0 or 1. For 9-bit data, `mp_en` is ignored, parity settings apply and `rx_mp_bit` reads 0.
- R5: When multiprocessor mode is in effect, the bit after the data is the MP bit and is shown on `rx_mp_bit`. `par_en` and `par_odd` have no effect, and `par_err` is never set.
- R6: While `wake_en` is 1 in multiprocessor mode, a frame with MP bit 0 is discarded. No flag is set, and `rx_data`, `rx_mp_bit` and `wake_en` keep their values.
- R7: While `wake_en` is 1 in multiprocessor mode, a frame with MP bit 1 clears `wake_en`. That frame is delivered with `rx_done` and the error flags updated as usual.
- R8: With `wake_en` at 0 in multiprocessor mode, every frame is delivered whatever its MP bit.
- R9: When multiprocessor mode is not in effect, `wake_en` neither discards frames nor gets cleared.
- R10: A stop bit sampled low sets `frm_err`. It stays set until `clr_err`.
- R11: A delivered frame that completes while `rx_done` is still 1 sets `ovr_err`, and the new data replace the old.
- R12: With `filt_en` at 1, an inverted pulse of three or fewer ticks on `rxd` has no effect on the received data. With `filt_en` at 0, the same pulse at a bit centre corrupts that bit.
- R13: A low pulse shorter than half a bit is taken as a false start and produces no frame and no flag.
- R14: `clr_done` clears only `rx_done`. `clr_err` clears only the three error flags. `wake_arm` sets `wake_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| os_tick | input | 1 | 16x oversampling enable, one clock wide |
| rxd | input | 1 | Serial line, idle high |
| len_code | input | 2 | Data length select |
| par_en | input | 1 | Parity enable |
| par_odd | input | 1 | Odd parity select |
| mp_en | input | 1 | Multiprocessor mode request |
| filt_en | input | 1 | Line filter enable |
| wake_arm | input | 1 | Sets the wake flag |
| clr_done | input | 1 | Clears the receive-complete flag |
| clr_err | input | 1 | Clears the error flags |
| rx_data | output | 9 | Received data, right-aligned |
| rx_mp_bit | output | 1 | MP bit of the last delivered frame |
| rx_done | output | 1 | Receive-complete flag |
| ovr_err | output | 1 | Overrun flag |
| frm_err | output | 1 | Framing error flag |
| par_err | output | 1 | Parity error flag |
| wake_en | output | 1 | Wake flag |

## Verification
The hardest case to reach is a discarded frame that would have raised an error. To check that it really leaves no trace, the bench first delivers a frame with a known MP bit and data. It then arms the wake flag and sends a non-address frame with a low stop bit. After that frame, the earlier data must remain, no flag may be set, and the wake flag must still be 1. A filter glitch is placed so that its three ticks straddle the sampling instant of one data bit. The same frame is sent with the filter on and with it off, so each outcome comes from the filter alone.

// File: rtl/mprx_pkg.sv
package mprx_pkg;

    localparam int MAX_BITS = 9;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_EXTRA,
        RX_STOP
    } rx_state_e;

    // number of data bits selected by the length code
    function automatic int data_bits(input logic [1:0] code);
        case (code)
            2'd0:    return 7;
            2'd1:    return 8;
            default: return 9;
        endcase
    endfunction

    // address-marker mode is legal only for the two short lengths
    function automatic logic mp_allowed(input logic [1:0] code);
        return (code == 2'd0) || (code == 2'd1);
    endfunction

endpackage

// File: rtl/mprx_glitch_filter.sv
module mprx_glitch_filter #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic enable,
    input  logic raw_in,
    output logic clean_out
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [1:0]    sync_q;
    logic          line;
    logic          level_q;
    logic [CW-1:0] run_q;

    assign line = sync_q[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], raw_in};
    end

    // the level moves only after FILT_LEN consecutive ticks of disagreement
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= 1'b1;
            run_q   <= '0;
        end else if (!enable) begin
            level_q <= line;
            run_q   <= '0;
        end else if (tick) begin
            if (line == level_q) begin
                run_q <= '0;
            end else if (run_q == CW'(FILT_LEN - 1)) begin
                level_q <= line;
                run_q   <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    assign clean_out = level_q;

    assert_filter_run_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
        run_q < CW'(FILT_LEN))
        else $error("filter run counter out of range");

    assert_filter_flip_on_tick_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(enable) && (level_q != $past(level_q))) |-> $past(tick))
        else $error("filtered level moved without a tick");

endmodule

// File: rtl/mprx_frame_fsm.sv
module mprx_frame_fsm
    import mprx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                line,
    input  logic [3:0]          nbits,
    input  logic                extra_en,
    output logic                frame_done,
    output logic [MAX_BITS-1:0] shreg,
    output logic                extra_bit,
    output logic                stop_bit
);
    localparam int CW   = $clog2(OSR);
    localparam int IW   = $clog2(MAX_BITS + 1);
    localparam int HALF = OSR / 2 - 1;
    localparam int LAST = OSR - 1;

    rx_state_e           state_q, state_d;
    logic [CW-1:0]       cnt_q;
    logic [IW-1:0]       idx_q;
    logic [MAX_BITS-1:0] shreg_q;
    logic                extra_q, stop_q, done_q;
    logic                at_half, at_end, last_bit;

    assign at_half  = tick && (cnt_q == CW'(HALF));
    assign at_end   = tick && (cnt_q == CW'(LAST));
    assign last_bit = (idx_q == IW'(nbits - 4'd1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:  if (tick && !line) state_d = RX_START;
            RX_START: if (at_half)       state_d = line ? RX_IDLE : RX_DATA;
            RX_DATA:  if (at_end && last_bit)
                          state_d = extra_en ? RX_EXTRA : RX_STOP;
            RX_EXTRA: if (at_end)        state_d = RX_STOP;
            RX_STOP:  if (at_end)        state_d = RX_IDLE;
            default:                     state_d = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            idx_q   <= '0;
            shreg_q <= '0;
            extra_q <= 1'b0;
            stop_q  <= 1'b1;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                RX_IDLE: begin
                    cnt_q   <= '0;
                    idx_q   <= '0;
                    extra_q <= 1'b0;
                end
                RX_START: begin
                    if (tick) cnt_q <= at_half ? '0 : cnt_q + 1'b1;
                end
                RX_DATA: begin
                    if (tick) cnt_q <= at_end ? '0 : cnt_q + 1'b1;
                    if (at_end) begin
                        shreg_q <= {line, shreg_q[MAX_BITS-1:1]};
                        idx_q   <= idx_q + 1'b1;
                    end
                end
                RX_EXTRA: begin
                    if (tick)   cnt_q   <= at_end ? '0 : cnt_q + 1'b1;
                    if (at_end) extra_q <= line;
                end
                RX_STOP: begin
                    if (tick) cnt_q <= at_end ? '0 : cnt_q + 1'b1;
                    if (at_end) begin
                        stop_q <= line;
                        done_q <= 1'b1;
                    end
                end
                default: cnt_q <= '0;
            endcase
        end
    end

    assign frame_done = done_q;
    assign shreg      = shreg_q;
    assign extra_bit  = extra_q;
    assign stop_bit   = stop_q;

    assert_bit_index_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_DATA) |-> (idx_q < IW'(nbits)))
        else $error("data bit index past selected length");

    assert_done_in_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (state_q == RX_IDLE))
        else $error("frame reported outside idle");

endmodule

// File: rtl/mprx_status.sv
module mprx_status
    import mprx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_done,
    input  logic [MAX_BITS-1:0] shreg,
    input  logic                extra_bit,
    input  logic                stop_bit,
    input  logic [3:0]          nbits,
    input  logic                mp_eff,
    input  logic                par_en,
    input  logic                par_odd,
    input  logic                wake_arm,
    input  logic                clr_done,
    input  logic                clr_err,
    output logic [MAX_BITS-1:0] data_o,
    output logic                mp_bit_o,
    output logic                done_o,
    output logic                ovr_o,
    output logic                frm_o,
    output logic                par_o,
    output logic                wake_o
);
    logic [MAX_BITS-1:0] aligned;
    logic                par_bad, discard, accept, addr_hit;
    logic [MAX_BITS-1:0] data_q;
    logic                mp_q, done_q, ovr_q, frm_q, par_q, wake_q;

    always_comb begin
        aligned  = shreg >> (MAX_BITS - int'(nbits));
        par_bad  = par_en && !mp_eff && ((^aligned ^ extra_bit) != par_odd);
        discard  = mp_eff && wake_q && !extra_bit;
        addr_hit = frame_done && mp_eff && wake_q && extra_bit;
        accept   = frame_done && !discard;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            mp_q   <= 1'b0;
            done_q <= 1'b0;
            ovr_q  <= 1'b0;
            frm_q  <= 1'b0;
            par_q  <= 1'b0;
            wake_q <= 1'b0;
        end else begin
            if (clr_done) done_q <= 1'b0;
            if (clr_err) begin
                ovr_q <= 1'b0;
                frm_q <= 1'b0;
                par_q <= 1'b0;
            end
            if (accept) begin
                data_q <= aligned;
                mp_q   <= mp_eff && extra_bit;
                done_q <= 1'b1;
                if (done_q)   ovr_q <= 1'b1;
                if (!stop_bit) frm_q <= 1'b1;
                if (par_bad)  par_q <= 1'b1;
            end
            if (wake_arm)      wake_q <= 1'b1;
            else if (addr_hit) wake_q <= 1'b0;
        end
    end

    assign data_o   = data_q;
    assign mp_bit_o = mp_q;
    assign done_o   = done_q;
    assign ovr_o    = ovr_q;
    assign frm_o    = frm_q;
    assign par_o    = par_q;
    assign wake_o   = wake_q;

    assert_discard_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && mp_eff && wake_q && !extra_bit)
        |=> (!$rose(done_q) && !$rose(ovr_q) && !$rose(frm_q) && !$rose(par_q) && wake_q))
        else $error("discarded frame left a trace");

    assert_wake_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && mp_eff && wake_q && extra_bit && !wake_arm)
        |=> (!wake_q && done_q))
        else $error("address frame did not release wake flag");

    assert_mp_no_parity_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && mp_eff) |=> !$rose(par_q))
        else $error("parity error raised in multiprocessor mode");

    assert_wake_inert_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !mp_eff) |=> (done_q && (wake_q || !$past(wake_q))))
        else $error("wake flag acted outside multiprocessor mode");

    assert_overrun_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_q) |-> $past(done_q))
        else $error("overrun without pending frame");

endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx
    import mprx_pkg::*;
#(
    parameter int OSR      = 16,
    parameter int FILT_LEN = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                os_tick,
    input  logic                rxd,
    input  logic [1:0]          len_code,
    input  logic                par_en,
    input  logic                par_odd,
    input  logic                mp_en,
    input  logic                filt_en,
    input  logic                wake_arm,
    input  logic                clr_done,
    input  logic                clr_err,
    output logic [MAX_BITS-1:0] rx_data,
    output logic                rx_mp_bit,
    output logic                rx_done,
    output logic                ovr_err,
    output logic                frm_err,
    output logic                par_err,
    output logic                wake_en
);
    logic                line_clean;
    logic                mp_eff, extra_en;
    logic [3:0]          nbits;
    logic                frame_done, extra_bit, stop_bit;
    logic [MAX_BITS-1:0] shreg;

    assign mp_eff   = mp_en && mp_allowed(len_code);
    assign extra_en = mp_eff || par_en;
    assign nbits    = 4'(data_bits(len_code));

    mprx_glitch_filter #(.FILT_LEN(FILT_LEN)) u_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (os_tick),
        .enable    (filt_en),
        .raw_in    (rxd),
        .clean_out (line_clean)
    );

    mprx_frame_fsm #(.OSR(OSR)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (os_tick),
        .line       (line_clean),
        .nbits      (nbits),
        .extra_en   (extra_en),
        .frame_done (frame_done),
        .shreg      (shreg),
        .extra_bit  (extra_bit),
        .stop_bit   (stop_bit)
    );

    mprx_status u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_done (frame_done),
        .shreg      (shreg),
        .extra_bit  (extra_bit),
        .stop_bit   (stop_bit),
        .nbits      (nbits),
        .mp_eff     (mp_eff),
        .par_en     (par_en),
        .par_odd    (par_odd),
        .wake_arm   (wake_arm),
        .clr_done   (clr_done),
        .clr_err    (clr_err),
        .data_o     (rx_data),
        .mp_bit_o   (rx_mp_bit),
        .done_o     (rx_done),
        .ovr_o      (ovr_err),
        .frm_o      (frm_err),
        .par_o      (par_err),
        .wake_o     (wake_en)
    );

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!rx_done || rst_n))
        else $error("receive flag set while in reset");

endmodule

// File: tb/tb_mp_uart_rx.sv
module tb_mp_uart_rx;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int OSR        = 16;

    typedef struct packed {
        logic [3:0] req;
        logic [1:0] len;
        logic       pe, po, mp, arm;
        logic [8:0] data;
        logic       ex, st;
        logic       e_done;
        logic [8:0] e_data;
        logic       e_mp, e_frm, e_par, e_wake;
    } vec_t;

    // req, len, pe, po, mp, arm, data, ex, st | done, data, mp, frm, par, wake
    localparam vec_t VECS [12] = '{
        '{4'd2,  2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 9'h0A5, 1'b0, 1'b1, 1'b1, 9'h0A5, 1'b0, 1'b0, 1'b0, 1'b0}, // R2 8 bit
        '{4'd3,  2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 9'h035, 1'b0, 1'b1, 1'b1, 9'h035, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 even ok
        '{4'd3,  2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 9'h00F, 1'b0, 1'b1, 1'b1, 9'h00F, 1'b0, 1'b0, 1'b1, 1'b0}, // R3 odd bad
        '{4'd2,  2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 9'h1C3, 1'b0, 1'b1, 1'b1, 9'h1C3, 1'b0, 1'b0, 1'b0, 1'b0}, // R2 9 bit
        '{4'd8,  2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 9'h042, 1'b0, 1'b1, 1'b1, 9'h042, 1'b0, 1'b0, 1'b0, 1'b0}, // R8
        '{4'd5,  2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 9'h001, 1'b1, 1'b1, 1'b1, 9'h001, 1'b1, 1'b0, 1'b0, 1'b0}, // R5
        '{4'd6,  2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 9'h0FF, 1'b0, 1'b0, 1'b0, 9'h001, 1'b1, 1'b0, 1'b0, 1'b1}, // R6
        '{4'd7,  2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 9'h077, 1'b1, 1'b1, 1'b1, 9'h077, 1'b1, 1'b0, 1'b0, 1'b0}, // R7
        '{4'd4,  2'd2, 1'b1, 1'b0, 1'b1, 1'b1, 9'h155, 1'b0, 1'b1, 1'b1, 9'h155, 1'b0, 1'b0, 1'b1, 1'b1}, // R4 R9
        '{4'd7,  2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 9'h011, 1'b1, 1'b1, 1'b1, 9'h011, 1'b1, 1'b0, 1'b0, 1'b0}, // R7 7 bit
        '{4'd10, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 9'h03C, 1'b0, 1'b0, 1'b1, 9'h03C, 1'b0, 1'b1, 1'b0, 1'b0}, // R10
        '{4'd7,  2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 9'h06A, 1'b1, 1'b0, 1'b1, 9'h06A, 1'b1, 1'b1, 1'b0, 1'b0}  // R7 errors
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] tick_div = '0;
    logic       os_tick;
    logic       rxd = 1'b1;
    logic [1:0] len_code = 2'd1;
    logic       par_en = 1'b0, par_odd = 1'b0, mp_en = 1'b0, filt_en = 1'b0;
    logic       wake_arm = 1'b0, clr_done = 1'b0, clr_err = 1'b0;
    logic [8:0] rx_data;
    logic       rx_mp_bit, rx_done, ovr_err, frm_err, par_err, wake_en;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(negedge clk) tick_div <= tick_div + 2'd1;
    assign os_tick = (tick_div == 2'd0);

    mp_uart_rx dut (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
        .len_code(len_code), .par_en(par_en), .par_odd(par_odd), .mp_en(mp_en),
        .filt_en(filt_en), .wake_arm(wake_arm), .clr_done(clr_done), .clr_err(clr_err),
        .rx_data(rx_data), .rx_mp_bit(rx_mp_bit), .rx_done(rx_done), .ovr_err(ovr_err),
        .frm_err(frm_err), .par_err(par_err), .wake_en(wake_en)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        repeat (n * TICK_DIV) @(negedge clk);
    endtask

    task automatic send_bit(input logic b, input bit glitch);
        if (glitch) begin
            rxd = b;  wait_ticks(7);
            rxd = ~b; wait_ticks(3);
            rxd = b;  wait_ticks(6);
        end else begin
            rxd = b;  wait_ticks(OSR);
        end
    endtask

    task automatic send_frame(input int nb, input logic [8:0] d, input bit has_ex,
                              input logic ex, input logic st, input int glitch_bit);
        send_bit(1'b0, 1'b0);
        for (int i = 0; i < nb; i++) send_bit(d[i], i == glitch_bit);
        if (has_ex) send_bit(ex, 1'b0);
        if (st) begin
            send_bit(1'b1, 1'b0);
        end else begin
            rxd = 1'b0; wait_ticks(14);
            rxd = 1'b1; wait_ticks(2);
        end
        wait_ticks(10);
    endtask

    task automatic clear_flags();
        clr_done = 1'b1; clr_err = 1'b1;
        @(negedge clk);
        clr_done = 1'b0; clr_err = 1'b0;
    endtask

    function automatic int nbits_of(input logic [1:0] c);
        return (c == 2'd0) ? 7 : (c == 2'd1) ? 8 : 9;
    endfunction

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        chk("R1", "rx_done", 32'(rx_done), 0);
        chk("R1", "ovr_err", 32'(ovr_err), 0);
        chk("R1", "frm_err", 32'(frm_err), 0);
        chk("R1", "par_err", 32'(par_err), 0);
        chk("R1", "wake_en", 32'(wake_en), 0);
        chk("R1", "rx_data", 32'(rx_data), 0);
        chk("R1", "rx_mp_bit", 32'(rx_mp_bit), 0);
        wait_ticks(4);

        for (int v = 0; v < 12; v++) begin
            string tag;
            bit    mp_ok, has_ex;
            tag = $sformatf("R%0d", VECS[v].req);
            clear_flags();
            len_code = VECS[v].len; par_en = VECS[v].pe; par_odd = VECS[v].po; mp_en = VECS[v].mp;
            if (VECS[v].arm) begin
                wake_arm = 1'b1; @(negedge clk); wake_arm = 1'b0;
            end
            mp_ok  = VECS[v].mp && (VECS[v].len < 2'd2);
            has_ex = mp_ok || VECS[v].pe;
            send_frame(nbits_of(VECS[v].len), VECS[v].data, has_ex, VECS[v].ex, VECS[v].st, -1);
            chk(tag, $sformatf("vec%0d rx_done", v),   32'(rx_done),   32'(VECS[v].e_done));
            chk(tag, $sformatf("vec%0d rx_data", v),   32'(rx_data),   32'(VECS[v].e_data));
            chk(tag, $sformatf("vec%0d rx_mp_bit", v), 32'(rx_mp_bit), 32'(VECS[v].e_mp));
            chk(tag, $sformatf("vec%0d frm_err", v),   32'(frm_err),   32'(VECS[v].e_frm));
            chk(tag, $sformatf("vec%0d par_err", v),   32'(par_err),   32'(VECS[v].e_par));
            chk(tag, $sformatf("vec%0d wake_en", v),   32'(wake_en),   32'(VECS[v].e_wake));
            chk(tag, $sformatf("vec%0d ovr_err", v),   32'(ovr_err),   0);
        end

        // R11 overrun: two frames, no clear between
        clear_flags();
        len_code = 2'd1; par_en = 1'b0; mp_en = 1'b0;
        send_frame(8, 9'h012, 1'b0, 1'b0, 1'b1, -1);
        chk("R11", "ovr after first", 32'(ovr_err), 0);
        send_frame(8, 9'h034, 1'b0, 1'b0, 1'b1, -1);
        chk("R11", "ovr_err", 32'(ovr_err), 1);
        chk("R11", "rx_data replaced", 32'(rx_data), 32'h034);
        chk("R11", "rx_done", 32'(rx_done), 1);

        // R14 separate clears
        clr_done = 1'b1; @(negedge clk); clr_done = 1'b0; @(negedge clk);
        chk("R14", "rx_done cleared", 32'(rx_done), 0);
        chk("R14", "ovr kept", 32'(ovr_err), 1);
        clr_err = 1'b1; @(negedge clk); clr_err = 1'b0; @(negedge clk);
        chk("R14", "ovr cleared", 32'(ovr_err), 0);

        // R13 false start
        rxd = 1'b0; wait_ticks(3); rxd = 1'b1; wait_ticks(30);
        chk("R13", "no frame from short low", 32'(rx_done), 0);
        chk("R13", "no framing flag", 32'(frm_err), 0);
        send_frame(8, 9'h05A, 1'b0, 1'b0, 1'b1, -1);
        chk("R13", "next frame data", 32'(rx_data), 32'h05A);

        // R12 filter on: glitch at centre of bit 0 rejected
        clear_flags();
        filt_en = 1'b1; wait_ticks(8);
        send_frame(8, 9'h0C3, 1'b0, 1'b0, 1'b1, 0);
        chk("R12", "filtered data", 32'(rx_data), 32'h0C3);
        chk("R12", "filtered frm_err", 32'(frm_err), 0);
        // R12 filter off: same glitch corrupts bit 0
        clear_flags();
        filt_en = 1'b0; wait_ticks(8);
        send_frame(8, 9'h0C3, 1'b0, 1'b0, 1'b1, 0);
        chk("R12", "unfiltered data", 32'(rx_data), 32'h0C2);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog run did not finish actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

endmodule